// File: doc/BRIEF.md
# Iterative Carry-Loop Adder

This block adds two unsigned words of `WIDTH` bits (32 by default). It does not use a ripple chain or a fixed number of stages. It holds two working words and applies one whole-word step per clock. In each step the partial sum becomes the XOR of the two words. The new carry word is their AND moved up by one bit. The carry word replaces the first working word and the partial sum replaces the second. The loop stops on the first step whose new carry word is all zeros. At that point the second word is the sum, so the latency depends on the operand values.

Operands enter through a valid/ready input. `in_ready` is high only while the block is idle. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high, and the operands are captured on that edge. While a sum is being formed, `in_ready` is low and any `in_valid` is ignored, which is the only back-pressure the block applies. The producer keeps its operands until it sees `in_ready`. The result side has no ready signal: `out_valid` is a one-cycle pulse. `out_sum`, `out_carry` and `iter_count` hold their values until the next result.

A carry bit that leaves the top of the carry word is caught in a sticky flag and reported as the carry-out. The sum is taken modulo 2^WIDTH. `iter_count` reports how many steps the current or most recent operation has used.

Top module: `xa_adder`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid`, `out_sum`, `out_carry` and `iter_count` are all 0.
- R2: An operation is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the cycle after that edge.
- R3: While the block is busy, `in_valid` and the operand inputs have no effect: the result is that of the accepted operands, and no second operation starts.
- R4: `out_sum` equals `(in_a + in_b) mod 2^WIDTH`. It changes only on the edge where `out_valid` rises.
- R5: `out_carry` equals bit `WIDTH` of the full sum `in_a + in_b`. It is set even when the carry leaves the word on the first step.
- R6: `iter_count` is the number of steps taken. Each step sets the carry word to `(x & y) << 1` and the partial sum to `x ^ y`, starting from `x = in_a` and `y = in_b`, and ends on the first step whose new carry word is zero. When `in_a & in_b` is zero, the count is 1.
- R7: `iter_count` never exceeds `WIDTH`. Adding 1 to an all-ones word takes exactly `WIDTH` steps.
- R8: `out_valid` is high for exactly one cycle, and `in_ready` is 1 in that same cycle, so a new operation can be accepted on the edge that ends it.
- R9: `out_valid` rises on the `iter_count`-th clock edge after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `in_a`/`in_b` are offered |
| in_ready | output | 1 | Block is idle and will take operands |
| in_a | input | WIDTH | First operand, seeds the carry word |
| in_b | input | WIDTH | Second operand, seeds the partial sum |
| out_valid | output | 1 | One-cycle pulse: result is present |
| out_sum | output | WIDTH | Sum modulo 2^WIDTH |
| out_carry | output | 1 | Carry out of the top bit |
| iter_count | output | CNT_W = $clog2(WIDTH+1) | Steps taken by the current or last operation |

## Verification
The hardest situation to reach is a long operation that receives input traffic while it runs, because in that case a wrongly accepted operand would change the result. The stimulus creates it by starting the slowest case, 1 plus all ones, which keeps the block busy for the full `WIDTH` steps. During that time the bench holds `in_valid` high with unrelated operands, then checks the sum, the carry, the step count, and that no extra operation follows. A second hard case is a carry that escapes on the very first step (two words with only the top bit set). The bench feeds that directly to exercise the sticky carry-out on a one-step operation.

// File: rtl/xa_pkg.sv
package xa_pkg;
  typedef enum logic [0:0] {
    XA_IDLE = 1'b0,
    XA_BUSY = 1'b1
  } xa_state_e;
endpackage

// File: rtl/xa_step.sv
// One whole-word loop step: partial sum, shifted carry word, spilled bit.
module xa_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] carry_o,
  output logic [WIDTH-1:0] part_o,
  output logic             spill_o
);
  logic [WIDTH-1:0] both_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign part_o[i] = x_i[i] ^ y_i[i];
    assign both_w[i] = x_i[i] & y_i[i];
  end

  assign carry_o = {both_w[WIDTH-2:0], 1'b0};
  assign spill_o = both_w[WIDTH-1];
endmodule

// File: rtl/xa_ctrl.sv
// Sequencer: idle/busy state, step counter, one-cycle done pulse.
module xa_ctrl
  import xa_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             last_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] iter_o
);
  xa_state_e        state_q;
  logic [CNT_W-1:0] iter_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XA_IDLE;
      iter_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        XA_IDLE: begin
          if (start_i) begin
            state_q <= XA_BUSY;
            iter_q  <= '0;
          end
        end
        XA_BUSY: begin
          iter_q <= iter_q + CNT_W'(1);
          if (last_i) begin
            state_q <= XA_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= XA_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == XA_BUSY);
  assign done_o = done_q;
  assign iter_o = iter_q;
endmodule

// File: rtl/xa_datapath.sv
// Working words, sticky spill flag and the held result.
module xa_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             fin_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] carry_n_i,
  input  logic [WIDTH-1:0] part_n_i,
  input  logic             spill_n_i,
  output logic [WIDTH-1:0] x_o,
  output logic [WIDTH-1:0] y_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] x_q, y_q, sum_q;
  logic             spill_q, cout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      spill_q <= 1'b0;
    end else if (load_i) begin
      x_q     <= a_i;
      y_q     <= b_i;
      spill_q <= 1'b0;
    end else if (step_i) begin
      x_q     <= carry_n_i;
      y_q     <= part_n_i;
      spill_q <= spill_q | spill_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (fin_i) begin
      sum_q  <= part_n_i;
      cout_q <= spill_q | spill_n_i;
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign sum_o  = sum_q;
  assign cout_o = cout_q;
endmodule

// File: rtl/xa_adder.sv
module xa_adder #(
  parameter  int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry,
  output logic [CNT_W-1:0] iter_count
);
  logic             busy, start, last, fin, spill_n;
  logic [WIDTH-1:0] x_w, y_w, carry_n, part_n;

  assign in_ready = ~busy;
  assign start    = in_valid & ~busy;
  assign last     = (carry_n == '0);
  assign fin      = busy & last;

  xa_step #(.WIDTH(WIDTH)) u_step (
    .x_i     (x_w),
    .y_i     (y_w),
    .carry_o (carry_n),
    .part_o  (part_n),
    .spill_o (spill_n)
  );

  xa_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .last_i  (last),
    .busy_o  (busy),
    .done_o  (out_valid),
    .iter_o  (iter_count)
  );

  xa_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start),
    .step_i    (busy),
    .fin_i     (fin),
    .a_i       (in_a),
    .b_i       (in_b),
    .carry_n_i (carry_n),
    .part_n_i  (part_n),
    .spill_n_i (spill_n),
    .x_o       (x_w),
    .y_o       (y_w),
    .sum_o     (out_sum),
    .cout_o    (out_carry)
  );
endmodule

// File: rtl/xa_adder_chk.sv
module xa_adder_chk #(
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_sum,
  input logic             out_carry,
  input logic [CNT_W-1:0] iter_count
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);                            // R2
  AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_sum) && $stable(out_carry)));         // R4
  AST_ONE_STEP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (iter_count != '0));                                // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter_count <= CNT_W'(WIDTH));                                     // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                        // R8
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);                                          // R8
endmodule

bind xa_adder xa_adder_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_sum    (out_sum),
  .out_carry  (out_carry),
  .iter_count (iter_count)
);

// File: tb/test_xa_adder.sv
`timescale 1ns/1ps
module test_xa_adder;
  localparam int WIDTH = 32;
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [WIDTH-1:0] in_a = '0, in_b = '0;
  logic             out_valid;
  logic [WIDTH-1:0] out_sum;
  logic             out_carry;
  logic [CNT_W-1:0] iter_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xa_adder #(.WIDTH(WIDTH)) i_xa_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
    .out_carry(out_carry), .iter_count(iter_count)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Step count from the loop rule of R6.
  function automatic int ref_steps(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] x, y, t;
    int n;
    x = a; y = b; n = 0;
    do begin
      t = (x & y) << 1;
      y = x ^ y;
      x = t;
      n++;
    end while (x != '0 && n < 100);
    return n;
  endfunction

  // One operation; disturb holds in_valid high with other operands while busy.
  task automatic run_add(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input int exp_steps, input bit disturb);
    logic [WIDTH:0] full;
    int lat;
    full = {1'b0, a} + {1'b0, b};
    if (exp_steps < 0) exp_steps = ref_steps(a, b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    @(posedge clk);
    @(negedge clk);
    check("R2 busy after accept", {63'd0, in_ready}, 64'd0);
    check("R8 no repeat pulse", {63'd0, out_valid}, 64'd0);
    in_valid = disturb;
    in_a = ~a; in_b = a ^ 32'h5A5A_0F0F;
    lat = 0;
    while (!out_valid && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (!out_valid) check("R3 still busy", {63'd0, in_ready}, 64'd0);
    end
    in_valid = 1'b0;
    check("R4 sum", {32'd0, out_sum}, {32'd0, full[WIDTH-1:0]});
    check("R5 carry", {63'd0, out_carry}, {63'd0, full[WIDTH]});
    check("R6 steps", {58'd0, iter_count}, 64'(exp_steps));
    check("R9 latency", 64'(lat), 64'(exp_steps));
    check("R8 ready with result", {63'd0, in_ready}, 64'd1);
    if (disturb) begin
      @(negedge clk);
      check("R3 nothing started", {63'd0, in_ready}, 64'd1);
      check("R3 result kept", {32'd0, out_sum}, {32'd0, full[WIDTH-1:0]});
    end
  endtask

  task automatic t_reset;
    check("R1 ready", {63'd0, in_ready}, 64'd1);
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 sum", {32'd0, out_sum}, 64'd0);
    check("R1 carry", {63'd0, out_carry}, 64'd0);
    check("R1 steps", {58'd0, iter_count}, 64'd0);
  endtask

  task automatic t_basic;
    run_add(32'd5, 32'd3, 4, 1'b0);            // R4 hand-worked: 4 steps
    run_add(32'd0, 32'hDEAD_BEEF, 1, 1'b0);    // R6 no common bits
    run_add(32'h1234_0000, 32'h0000_5678, 1, 1'b0);
  endtask

  task automatic t_worst;
    run_add(32'd1, 32'hFFFF_FFFF, WIDTH, 1'b0); // R7
    check("R7 bound", {58'd0, iter_count}, 64'(WIDTH));
    run_add(32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, 1'b0);
  endtask

  task automatic t_top_spill;
    run_add(32'h8000_0000, 32'h8000_0000, 1, 1'b0); // R5 carry on first step
  endtask

  task automatic t_disturb;
    run_add(32'd1, 32'hFFFF_FFFF, WIDTH, 1'b1);  // R3
  endtask

  task automatic t_back_to_back;  // R8: next accepted on the done cycle
    logic [WIDTH-1:0] a;
    for (int i = 0; i < 24; i++) begin
      a = (32'h9E37_79B9 * (i + 1)) ^ (32'h1 << i);
      run_add(a, ~a + 32'(i), -1, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_worst();
    t_top_spill();
    t_disturb();
    t_back_to_back();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule